// File: doc/BRIEF.md
# Register-Controlled General-Purpose I/O Port

This block owns one general-purpose I/O port of a configurable number of pins (eight by default). Software reaches it through a small register bus with three mapped locations. A direction register sets which pins drive. An output data register sets the value driven on output pins and, on input pins, requests a pull-up. A sampled input location returns the synchronized pad levels. That input location holds no storage of its own. A write to it flips the output data bits wherever the written data has a one, so one store can invert any group of outputs.

A separate single-bit port sets or clears one bit of either the direction or the output data register in a single cycle. It leaves every other bit untouched, so software never has to read, modify and write back the whole register. A global pull-up disable input, driven from a shared control register elsewhere in the chip, turns off every pull-up at once. Each pin also has a simple override from an alternate-function peripheral. An overridden pin takes its enable and value from that peripheral and leaves the other pins under register control.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the direction and output data registers hold zero, so every pin is an input. All of `pad_oe`, `pad_out`, `pad_pu` and `reg_rdata` are zero.
- R2: Register map by `reg_addr`: 0 is the sampled input location, 1 is direction and 2 is output data. A write with `reg_wr` high to address 1 or 2 replaces that register with `reg_wdata`. `reg_rdata` is registered: the edge that samples `reg_addr` loads the selected value, which appears after that edge. Address 3 reads zero.
- R3: A write to address 0 inverts every output data bit whose `reg_wdata` bit is one and leaves bits with a zero unchanged. The direction register is not affected.
- R4: With `bit_en` high, the edge sets (`bit_val`=1) or clears (`bit_val`=0) bit `bit_idx` of the direction register (`bit_sel`=0) or the output data register (`bit_sel`=1). No other bit of either register changes.
- R5: `pad_pu[n]` is one only when pin n is an input (direction bit 0), its output data bit is one, `pud` is low and `alt_en[n]` is low.
- R6: While `pud` is high, every bit of `pad_pu` is zero, whatever the register contents.
- R7: The input location returns `pad_in` through a two-flop synchronizer. The value loaded into `reg_rdata` at an edge is the `pad_in` value sampled two edges earlier.
- R8: A pin without override drives `pad_oe[n]` from its direction bit and `pad_out[n]` from its output data bit.
- R9: When `alt_en[n]` is high, `pad_oe[n]` and `pad_out[n]` follow `alt_oe[n]` and `alt_out[n]`, and the pin's pull-up is off. Every other pin and both registers are unaffected.
- R10: When a bit operation and a register write hit the same register in the same cycle, the bit operation decides its own bit and the register write decides the remaining bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register location select |
| reg_wdata | input | WIDTH | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | WIDTH | Registered read data |
| bit_en | input | 1 | Single-bit operation strobe |
| bit_idx | input | IDX_W | Bit index of the single-bit operation |
| bit_sel | input | 1 | Target: 0 direction, 1 output data |
| bit_val | input | 1 | 1 sets the bit, 0 clears it |
| pud | input | 1 | Global pull-up disable |
| pad_in | input | WIDTH | Raw pad input levels |
| alt_en | input | WIDTH | Per-pin alternate-function override enable |
| alt_oe | input | WIDTH | Override output enable |
| alt_out | input | WIDTH | Override output value |
| pad_oe | output | WIDTH | Pad output enable |
| pad_out | output | WIDTH | Pad output value |
| pad_pu | output | WIDTH | Pad pull-up enable |

## Verification
The bench builds the block with its defaults: eight pins and a two-stage synchronizer. With eight pins the 3-bit index of the single-bit port reaches every pin, including the first and the last. With two synchronizer stages the two-edge input latency can be predicted exactly. Random cycles mix simultaneous writes and bit operations, toggles through the input location, the global disable and partial overrides. Directed cases pin down the value arithmetic of toggling and of same-cycle priority.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      GP_LOC_PINS = 2'd0,
      GP_LOC_DIR  = 2'd1,
      GP_LOC_DATA = 2'd2,
      GP_LOC_NONE = 2'd3
   } gp_loc_e;

   typedef enum logic {
      GP_TGT_DIR  = 1'b0,
      GP_TGT_DATA = 1'b1
   } gp_tgt_e;

   localparam int GP_MAX_WIDTH = 32;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pad_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= pad_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];

   generate
      if (STAGES == 2) begin : g_lat_chk
         logic [1:0] age_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            age_q <= '0;
            else if (age_q != 2'd2) age_q <= age_q + 2'd1;
         end
         p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd2) |-> (sync_o == $past(pad_i, 2)));
      end
   endgenerate

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       addr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             wr_i,
   input  logic             bit_en_i,
   input  logic [IDX_W-1:0] bit_idx_i,
   input  logic             bit_sel_i,
   input  logic             bit_val_i,
   output logic [WIDTH-1:0] dir_o,
   output logic [WIDTH-1:0] data_o
);

   logic [WIDTH-1:0] dir_q, data_q;
   logic [WIDTH-1:0] dir_n, data_n;
   logic             idx_ok;

   assign idx_ok = (int'(bit_idx_i) < WIDTH);

   always_comb begin
      dir_n  = dir_q;
      data_n = data_q;
      if (wr_i) begin
         case (addr_i)
            GP_LOC_PINS: data_n = data_q ^ wdata_i;
            GP_LOC_DIR:  dir_n  = wdata_i;
            GP_LOC_DATA: data_n = wdata_i;
            default: ;
         endcase
      end
      if (bit_en_i && idx_ok) begin
         if (bit_sel_i == GP_TGT_DATA) data_n[bit_idx_i] = bit_val_i;
         else                          dir_n[bit_idx_i]  = bit_val_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         data_q <= '0;
      end else begin
         dir_q  <= dir_n;
         data_q <= data_n;
      end
   end

   assign dir_o  = dir_q;
   assign data_o = data_q;

   logic [WIDTH-1:0] chk_mask;
   assign chk_mask = WIDTH'(1) << bit_idx_i;

   p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == GP_LOC_PINS && !bit_en_i)
      |=> (data_q == ($past(data_q) ^ $past(wdata_i))) && $stable(dir_q));

   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == GP_LOC_DIR && !bit_en_i) |=> (dir_q == $past(wdata_i)));

   p_bitop_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en_i && !wr_i && bit_sel_i == GP_TGT_DIR)
      |=> (((dir_q ^ $past(dir_q)) & ~$past(chk_mask)) == '0)
          && ((dir_q & $past(chk_mask)) == ($past(bit_val_i) ? $past(chk_mask) : '0))
          && $stable(data_q));

   p_bitop_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en_i && !wr_i && bit_sel_i == GP_TGT_DATA)
      |=> (((data_q ^ $past(data_q)) & ~$past(chk_mask)) == '0)
          && ((data_q & $past(chk_mask)) == ($past(bit_val_i) ? $past(chk_mask) : '0))
          && $stable(dir_q));

   p_same_cycle_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en_i && wr_i && addr_i == GP_LOC_DIR && bit_sel_i == GP_TGT_DIR)
      |=> ((dir_q & $past(chk_mask)) == ($past(bit_val_i) ? $past(chk_mask) : '0))
          && ((dir_q & ~$past(chk_mask)) == ($past(wdata_i) & ~$past(chk_mask))));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] dir_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic             pud_i,
   input  logic [WIDTH-1:0] alt_en_i,
   input  logic [WIDTH-1:0] alt_oe_i,
   input  logic [WIDTH-1:0] alt_out_i,
   output logic [WIDTH-1:0] pad_oe_o,
   output logic [WIDTH-1:0] pad_out_o,
   output logic [WIDTH-1:0] pad_pu_o
);

   generate
      for (genvar n = 0; n < WIDTH; n++) begin : g_pin
         logic pu_req;
         assign pu_req       = !dir_i[n] && data_i[n];
         assign pad_oe_o[n]  = alt_en_i[n] ? alt_oe_i[n]  : dir_i[n];
         assign pad_out_o[n] = alt_en_i[n] ? alt_out_i[n] : data_i[n];
         assign pad_pu_o[n]  = pu_req && !alt_en_i[n] && !pud_i;
      end
   endgenerate

endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       addr_i,
   input  logic [WIDTH-1:0] pins_i,
   input  logic [WIDTH-1:0] dir_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] rdata_o
);

   logic [WIDTH-1:0] sel_d;
   logic [WIDTH-1:0] rdata_q;

   always_comb begin
      case (addr_i)
         GP_LOC_PINS: sel_d = pins_i;
         GP_LOC_DIR:  sel_d = dir_i;
         GP_LOC_DATA: sel_d = data_i;
         default:     sel_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= sel_d;
   end

   assign rdata_o = rdata_q;

   p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == GP_LOC_NONE) |=> (rdata_o == '0));

   p_read_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == GP_LOC_DIR) |=> (rdata_o == $past(dir_i)));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int IDX_W       = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_addr,
   input  logic [WIDTH-1:0] reg_wdata,
   input  logic             reg_wr,
   output logic [WIDTH-1:0] reg_rdata,
   input  logic             bit_en,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             bit_sel,
   input  logic             bit_val,
   input  logic             pud,
   input  logic [WIDTH-1:0] pad_in,
   input  logic [WIDTH-1:0] alt_en,
   input  logic [WIDTH-1:0] alt_oe,
   input  logic [WIDTH-1:0] alt_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu
);

   generate
      if (WIDTH < 1 || WIDTH > GP_MAX_WIDTH) begin : g_bad_width
         $error("gpio_port_ctrl: WIDTH out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port_ctrl: SYNC_STAGES must be at least 2");
      end
      if ((1 << IDX_W) < WIDTH) begin : g_bad_idx
         $error("gpio_port_ctrl: IDX_W too narrow for WIDTH");
      end
   endgenerate

   logic [WIDTH-1:0] dir_w, data_w, pins_w;

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_i  (pad_in),
      .sync_o (pins_w)
   );

   gpio_regfile #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (reg_addr),
      .wdata_i   (reg_wdata),
      .wr_i      (reg_wr),
      .bit_en_i  (bit_en),
      .bit_idx_i (bit_idx),
      .bit_sel_i (bit_sel),
      .bit_val_i (bit_val),
      .dir_o     (dir_w),
      .data_o    (data_w)
   );

   gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
      .dir_i     (dir_w),
      .data_i    (data_w),
      .pud_i     (pud),
      .alt_en_i  (alt_en),
      .alt_oe_i  (alt_oe),
      .alt_out_i (alt_out),
      .pad_oe_o  (pad_oe),
      .pad_out_o (pad_out),
      .pad_pu_o  (pad_pu)
   );

   gpio_read_port #(.WIDTH(WIDTH)) u_read (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (reg_addr),
      .pins_i  (pins_w),
      .dir_i   (dir_w),
      .data_i  (data_w),
      .rdata_o (reg_rdata)
   );

   p_pud_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pud |-> (pad_pu == '0));

   p_pu_inputs_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu & (dir_w | ~data_w | alt_en)) == '0));

   p_plain_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~alt_en) == (dir_w & ~alt_en)) && ((pad_out & ~alt_en) == (data_w & ~alt_en)));

   p_override_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & alt_en) == (alt_oe & alt_en)) && ((pad_out & alt_en) == (alt_out & alt_en)));

   p_override_keeps_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && !bit_en) |=> ($stable(dir_w) && $stable(data_w)));

endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   reg_addr = '0;
   logic [W-1:0] reg_wdata = '0;
   logic         reg_wr = 1'b0;
   logic [W-1:0] reg_rdata;
   logic         bit_en = 1'b0;
   logic [2:0]   bit_idx = '0;
   logic         bit_sel = 1'b0;
   logic         bit_val = 1'b0;
   logic         pud = 1'b0;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] alt_en = '0;
   logic [W-1:0] alt_oe = '0;
   logic [W-1:0] alt_out = '0;
   logic [W-1:0] pad_oe, pad_out, pad_pu;

   int n_checks = 0;
   int n_fails  = 0;
   bit run_cmp  = 1'b0;

   always #5 clk = ~clk;

   gpio_port_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
      .bit_en(bit_en), .bit_idx(bit_idx), .bit_sel(bit_sel), .bit_val(bit_val),
      .pud(pud), .pad_in(pad_in),
      .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );

   // behavioural reference
   int m_dir, m_data, m_rd, m_s1, m_s2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dir = 0; m_data = 0; m_rd = 0; m_s1 = 0; m_s2 = 0;
      end else begin
         int nd, nda, rd;
         case (reg_addr)
            2'd0: rd = m_s2;
            2'd1: rd = m_dir;
            2'd2: rd = m_data;
            default: rd = 0;
         endcase
         m_s2 = m_s1;
         m_s1 = int'(pad_in);
         nd = m_dir; nda = m_data;
         if (reg_wr) begin
            if (reg_addr == 2'd0) nda = m_data ^ int'(reg_wdata);
            else if (reg_addr == 2'd1) nd = int'(reg_wdata);
            else if (reg_addr == 2'd2) nda = int'(reg_wdata);
         end
         if (bit_en) begin
            if (bit_sel) nda = bit_val ? (nda | (1 << bit_idx)) : (nda & ~(1 << bit_idx));
            else         nd  = bit_val ? (nd  | (1 << bit_idx)) : (nd  & ~(1 << bit_idx));
         end
         m_dir = nd; m_data = nda; m_rd = rd;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (run_cmp) begin
         int e_oe, e_out, e_pu, ae;
         ae    = int'(alt_en);
         e_oe  = ((m_dir & ~ae) | (int'(alt_oe) & ae)) & 8'hFF;
         e_out = ((m_data & ~ae) | (int'(alt_out) & ae)) & 8'hFF;
         e_pu  = pud ? 0 : (~m_dir & m_data & ~ae & 8'hFF);
         check("R8/R9 pad_oe", int'(pad_oe), e_oe);
         check("R8/R9 pad_out", int'(pad_out), e_out);
         check("R5/R6 pad_pu", int'(pad_pu), e_pu);
         check("R2/R7 reg_rdata", int'(reg_rdata), m_rd & 8'hFF);
      end
   end

   // each task starts just after a falling edge and consumes one cycle
   task automatic idle();
      reg_wr = 1'b0; bit_en = 1'b0;
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic bop(input logic sel, input logic [2:0] idx, input logic val);
      bit_sel = sel; bit_idx = idx; bit_val = val; bit_en = 1'b1;
      @(negedge clk); #1;
      bit_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      reg_addr = a; reg_wr = 1'b0; bit_en = 1'b0;
      @(negedge clk);
      v = int'(reg_rdata);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      run_cmp = 1'b1;
      // R1: reset state
      check("R1 pad_oe", int'(pad_oe), 0);
      check("R1 pad_out", int'(pad_out), 0);
      check("R1 pad_pu", int'(pad_pu), 0);
      check("R1 reg_rdata", int'(reg_rdata), 0);
      rd(2'd1, v); check("R1 dir read", v, 0);
      // R2: direction write and readback
      wr(2'd1, 8'hA5);
      rd(2'd1, v); check("R2 dir readback", v, 8'hA5);
      // R3: toggle through the input location
      wr(2'd2, 8'h0F);
      wr(2'd0, 8'h3C);
      rd(2'd2, v); check("R3 toggled data", v, 8'h33);
      rd(2'd1, v); check("R3 dir untouched", v, 8'hA5);
      // R4: single-bit operations, top and bottom index
      bop(1'b0, 3'd6, 1'b1);
      rd(2'd1, v); check("R4 dir bit6 set", v, 8'hE5);
      bop(1'b1, 3'd0, 1'b0);
      rd(2'd2, v); check("R4 data bit0 clear", v, 8'h32);
      rd(2'd1, v); check("R4 dir unchanged", v, 8'hE5);
      bop(1'b1, 3'd7, 1'b1);
      rd(2'd2, v); check("R4 data bit7 set", v, 8'hB2);
      // R10: same-cycle write and bit operation
      reg_addr = 2'd1; reg_wdata = 8'h00; reg_wr = 1'b1;
      bop(1'b0, 3'd3, 1'b1);
      rd(2'd1, v); check("R10 bit op wins its bit", v, 8'h08);
      // R5 / R6: pull-ups
      wr(2'd1, 8'h00);
      wr(2'd2, 8'hFF);
      check("R5 pull-ups on inputs", int'(pad_pu), 8'hFF);
      pud = 1'b1; #1;
      check("R6 global disable", int'(pad_pu), 0);
      pud = 1'b0;
      // R9: override on pin 2 only
      wr(2'd1, 8'h0F);
      wr(2'd2, 8'hF0);
      alt_en = 8'h04; alt_oe = 8'h04; alt_out = 8'h04; #1;
      check("R9 pad_oe", int'(pad_oe), 8'h0F);
      check("R9 pad_out", int'(pad_out), 8'hF4);
      check("R9 pad_pu", int'(pad_pu), 8'hF0);
      rd(2'd2, v); check("R9 data kept", v, 8'hF0);
      alt_en = '0; alt_oe = '0; alt_out = '0;
      // R7: synchronized pad input
      pad_in = 8'h5A;
      idle(); idle(); idle();
      rd(2'd0, v); check("R7 pins read", v, 8'h5A);
      rd(2'd3, v); check("R2 unmapped reads zero", v, 0);
      // random traffic against the reference model
      for (int i = 0; i < 4000; i++) begin
         reg_addr  = 2'($urandom_range(0, 3));
         reg_wdata = 8'($urandom);
         reg_wr    = ($urandom_range(0, 2) == 0);
         bit_en    = ($urandom_range(0, 2) == 0);
         bit_idx   = 3'($urandom);
         bit_sel   = 1'($urandom);
         bit_val   = 1'($urandom);
         pud       = ($urandom_range(0, 3) == 0);
         pad_in    = 8'($urandom);
         alt_en    = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom);
         alt_oe    = 8'($urandom);
         alt_out   = 8'($urandom);
         @(negedge clk); #1;
      end
      reg_wr = 1'b0; bit_en = 1'b0;
      idle();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule